// File: doc/BRIEF.md
# Nested Residue Modular Multiplier

This block multiplies two numbers that are already held as residue tuples over the outer moduli 7, 11 and 13, whose product 1001 is the dynamic range. Each tuple channel is multiplied on its own, so no carries cross between channels. The modulus-7 channel is multiplied and reduced directly in a 3-bit datapath.

The two wider channels, modulus 11 and modulus 13, reuse one small inner residue system over 5, 6 and 7. Each operand residue is split into its inner residues. The inner residues are multiplied pairwise, each modulo its own inner modulus. The inner product is rebuilt into a binary value by the Chinese remainder theorem over the inner range 0..209, and that value is reduced by 11 or 13. Every multiplier therefore stays 3 bits wide, and the same inner moduli serve both wide channels.

Operands enter with a valid strobe. The product tuple leaves a fixed three cycles later with its own valid strobe. A new operand pair may be issued on every cycle. Conversion between plain binary and the outer tuple, and any accumulation, are done outside this block.

Top module: `nrm_mul`

## Requirements
- R1: While reset is held and after its release, before any valid input, `out_valid` is 0 and all three product residues are 0.
- R2: `out_valid` is high in exactly those cycles that come three clock edges after a cycle in which `in_valid` was sampled high.
- R3: The modulus-7 output residue equals (a7 × b7) mod 7 for all operand residues 0..6.
- R4: The modulus-11 output residue equals (a11 × b11) mod 11 for all operand residues 0..10, computed through the inner 5/6/7 system.
- R5: The modulus-13 output residue equals (a13 × b13) mod 13 for all operand residues 0..12, computed through the inner 5/6/7 system.
- R6: For integers A and B in 0..1000 given as tuples (A mod 7, A mod 11, A mod 13), the output tuple is the tuple of (A × B) mod 1001. For example, 19 × 22 gives (5, 0, 2), which represents 418.
- R7: Every output residue with `out_valid` high is below its modulus: 7, 11 or 13.
- R8: The value rebuilt from the inner products never exceeds (M−1)² for the channel modulus M, and its residues mod 5, 6 and 7 match the inner products. The largest operands (6, 10, 12) squared give the tuple (1, 1, 1).
- R9: In any cycle with `out_valid` low, the product outputs keep the value they had in the previous cycle.
- R10: Operand pairs issued on consecutive cycles, with or without gaps, each produce exactly one result, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair valid |
| a_r7 | input | 3 | Operand A residue mod 7 |
| a_r11 | input | 4 | Operand A residue mod 11 |
| a_r13 | input | 4 | Operand A residue mod 13 |
| b_r7 | input | 3 | Operand B residue mod 7 |
| b_r11 | input | 4 | Operand B residue mod 11 |
| b_r13 | input | 4 | Operand B residue mod 13 |
| out_valid | output | 1 | Product tuple valid |
| p_r7 | output | 3 | Product residue mod 7 |
| p_r11 | output | 4 | Product residue mod 11 |
| p_r13 | output | 4 | Product residue mod 13 |

## Verification
A wrong inner residue or a wrong reconstruction weight corrupts only the channel it belongs to. It shows up three cycles after issue as a wrong p_r11 or p_r13 for particular operand values. An exhaustive sweep of all 13 × 13 residue pairs therefore exposes any single bad table entry on the first pass. A slip in the valid pipeline shows up at once as a result arriving in the wrong cycle, or as an output that moves while `out_valid` is low. The 1001-value integer sweep then confirms that the three channels together represent the right product.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

  // Inner moduli and the inner dynamic range
  localparam int unsigned IN_A = 5;
  localparam int unsigned IN_B = 6;
  localparam int unsigned IN_C = 7;
  localparam int unsigned IN_RANGE = IN_A * IN_B * IN_C;

  // Reconstruction weights: each is 1 mod its own modulus, 0 mod the others
  localparam int unsigned WT_A = 126;
  localparam int unsigned WT_B = 175;
  localparam int unsigned WT_C = 120;

  typedef struct packed {
    logic [2:0] ra;
    logic [2:0] rb;
    logic [2:0] rc;
  } inner_t;

  function automatic inner_t to_inner(input logic [3:0] v);
    int unsigned t;
    inner_t o;
    t = {28'd0, v};
    o.ra = 3'(t % IN_A);
    o.rb = 3'(t % IN_B);
    o.rc = 3'(t % IN_C);
    return o;
  endfunction

  function automatic logic [2:0] mul_small(input logic [2:0] a, input logic [2:0] b,
                                           input int unsigned m);
    int unsigned t;
    t = {29'd0, a} * {29'd0, b};
    return 3'(t % m);
  endfunction

  function automatic logic [7:0] from_inner(input inner_t p);
    int unsigned s;
    s = WT_A * {29'd0, p.ra} + WT_B * {29'd0, p.rb} + WT_C * {29'd0, p.rc};
    return 8'(s % IN_RANGE);
  endfunction

endpackage

// File: rtl/nrm_direct_chan.sv
module nrm_direct_chan #(
  parameter int unsigned M = 7,
  localparam int W = $clog2(M)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   stage_en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] prod_mod;

  always_comb begin
    int unsigned t;
    t = 32'(a) * 32'(b);
    prod_mod = W'(t % M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      y    <= '0;
    end else begin
      if (stage_en[0]) s1_q <= prod_mod;
      if (stage_en[1]) s2_q <= s1_q;
      if (stage_en[2]) y    <= s2_q;
    end
  end

  AST_DIRECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en[1] |-> (32'(s1_q) < M)); // R3

endmodule

// File: rtl/nrm_nested_chan.sv
module nrm_nested_chan
  import nrm_pkg::*;
#(
  parameter int unsigned M = 11,
  localparam int W = $clog2(M)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   stage_en,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  inner_t a_in_q, b_in_q;
  inner_t prod_q;
  inner_t prod_d;
  logic [7:0] recon;

  always_comb begin
    prod_d.ra = mul_small(a_in_q.ra, b_in_q.ra, IN_A);
    prod_d.rb = mul_small(a_in_q.rb, b_in_q.rb, IN_B);
    prod_d.rc = mul_small(a_in_q.rc, b_in_q.rc, IN_C);
  end

  assign recon = from_inner(prod_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_in_q <= '0;
      b_in_q <= '0;
      prod_q <= '0;
      y      <= '0;
    end else begin
      if (stage_en[0]) begin
        a_in_q <= to_inner(4'(a));
        b_in_q <= to_inner(4'(b));
      end
      if (stage_en[1]) prod_q <= prod_d;
      if (stage_en[2]) y <= W'(32'(recon) % M);
    end
  end

  AST_INNER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en[2] |-> (32'(recon) <= (M - 1) * (M - 1))); // R8
  AST_INNER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    stage_en[2] |-> ((32'(recon) % IN_A == 32'(prod_q.ra)) &&
                     (32'(recon) % IN_B == 32'(prod_q.rb)) &&
                     (32'(recon) % IN_C == 32'(prod_q.rc)))); // R8

endmodule

// File: rtl/nrm_mul.sv
module nrm_mul #(
  parameter int unsigned M_A = 7,
  parameter int unsigned M_B = 11,
  parameter int unsigned M_C = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [$clog2(M_A)-1:0] a_r7,
  input  logic [$clog2(M_B)-1:0] a_r11,
  input  logic [$clog2(M_C)-1:0] a_r13,
  input  logic [$clog2(M_A)-1:0] b_r7,
  input  logic [$clog2(M_B)-1:0] b_r11,
  input  logic [$clog2(M_C)-1:0] b_r13,
  output logic                   out_valid,
  output logic [$clog2(M_A)-1:0] p_r7,
  output logic [$clog2(M_B)-1:0] p_r11,
  output logic [$clog2(M_C)-1:0] p_r13
);
  logic v1_q, v2_q;
  logic [2:0] stage_en;

  assign stage_en = {v2_q, v1_q, in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= in_valid;
      v2_q      <= v1_q;
      out_valid <= v2_q;
    end
  end

  nrm_direct_chan #(.M(M_A)) u_ch_a (
    .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .a(a_r7), .b(b_r7), .y(p_r7));

  nrm_nested_chan #(.M(M_B)) u_ch_b (
    .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .a(a_r11), .b(b_r11), .y(p_r11));

  nrm_nested_chan #(.M(M_C)) u_ch_c (
    .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .a(a_r13), .b(b_r13), .y(p_r13));

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3)); // R2
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(p_r7) < M_A && 32'(p_r11) < M_B && 32'(p_r13) < M_C)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(p_r7) && $stable(p_r11) && $stable(p_r13))); // R9

endmodule

// File: tb/tb_nrm_mul.sv
module tb_nrm_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] a_r7 = '0, b_r7 = '0;
  logic [3:0] a_r11 = '0, b_r11 = '0, a_r13 = '0, b_r13 = '0;
  logic out_valid;
  logic [2:0] p_r7;
  logic [3:0] p_r11, p_r13;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int issued = 0;
  int received = 0;
  bit done = 1'b0;
  bit summary_done = 1'b0;

  int q_e7[$], q_e11[$], q_e13[$], q_cyc[$], q_mode[$];
  logic [2:0] last7 = '0;
  logic [3:0] last11 = '0, last13 = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nrm_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_r7(a_r7), .a_r11(a_r11), .a_r13(a_r13),
    .b_r7(b_r7), .b_r11(b_r11), .b_r13(b_r13),
    .out_valid(out_valid), .p_r7(p_r7), .p_r11(p_r11), .p_r13(p_r13));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // Small search over 0..1000 for the integer a tuple stands for
  function automatic int tuple_value(input int r7, input int r11, input int r13);
    for (int k = 0; k < 1001; k++)
      if (k % 7 == r7 && k % 11 == r11 && k % 13 == r13) return k;
    return -1;
  endfunction

  task automatic issue(input int x7, input int x11, input int x13,
                       input int y7, input int y11, input int y13,
                       input int e7, input int e11, input int e13, input int mode);
    @(negedge clk);
    in_valid = 1'b1;
    a_r7 = 3'(x7);  a_r11 = 4'(x11); a_r13 = 4'(x13);
    b_r7 = 3'(y7);  b_r11 = 4'(y11); b_r13 = 4'(y13);
    q_e7.push_back(e7); q_e11.push_back(e11); q_e13.push_back(e13);
    q_cyc.push_back(cyc); q_mode.push_back(mode);
    issued++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_r7 = 3'd5; a_r11 = 4'd9; a_r13 = 4'd11;
    end
  endtask

  // Monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (q_e7.size() == 0) begin
          chk(1'b0, "R10 unexpected result", 1, 0);
        end else begin
          int e7, e11, e13, c0, md;
          string r7s, r11s, r13s;
          e7 = q_e7.pop_front(); e11 = q_e11.pop_front(); e13 = q_e13.pop_front();
          c0 = q_cyc.pop_front(); md = q_mode.pop_front();
          received++;
          r7s  = (md == 0) ? "R3" : (md == 1) ? "R6" : "R8";
          r11s = (md == 0) ? "R4" : (md == 1) ? "R6" : "R8";
          r13s = (md == 0) ? "R5" : (md == 1) ? "R6" : "R8";
          chk(cyc - c0 == 3, "R2 latency", cyc - c0, 3);
          chk(int'(p_r7) == e7, r7s, int'(p_r7), e7);
          chk(int'(p_r11) == e11, r11s, int'(p_r11), e11);
          chk(int'(p_r13) == e13, r13s, int'(p_r13), e13);
          chk(p_r7 < 7 && p_r11 < 11 && p_r13 < 13, "R7 range",
              int'(p_r13), 12);
        end
        last7 = p_r7; last11 = p_r11; last13 = p_r13;
      end else begin
        chk(p_r7 == last7 && p_r11 == last11 && p_r13 == last13, "R9 hold",
            int'(p_r13), int'(last13));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && p_r7 == 0 && p_r11 == 0 && p_r13 == 0, "R1 in reset",
        int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && p_r7 == 0 && p_r11 == 0 && p_r13 == 0, "R1 after release",
        int'(out_valid), 0);

    // R3 R4 R5: every residue pair of each channel, back to back (R10)
    for (int x = 0; x < 13; x++)
      for (int y = 0; y < 13; y++)
        issue(x % 7, x % 11, x, y % 7, y % 11, y,
              ((x % 7) * (y % 7)) % 7, ((x % 11) * (y % 11)) % 11, (x * y) % 13, 0);
    idle(5);

    // R8: largest operands in every channel
    issue(6, 10, 12, 6, 10, 12, 1, 1, 1, 2);
    idle(4);

    // R6: the worked example 19 x 22, then an integer sweep with gaps
    issue(19 % 7, 19 % 11, 19 % 13, 22 % 7, 22 % 11, 22 % 13,
          418 % 7, 418 % 11, 418 % 13, 1);
    idle(4);
    chk(tuple_value(int'(p_r7), int'(p_r11), int'(p_r13)) == 418, "R6 example 19x22",
        tuple_value(int'(p_r7), int'(p_r11), int'(p_r13)), 418);
    for (int a = 0; a < 1001; a++) begin
      int b, pr;
      b = (a * 37 + 5) % 1001;
      pr = (a * b) % 1001;
      issue(a % 7, a % 11, a % 13, b % 7, b % 11, b % 13, pr % 7, pr % 11, pr % 13, 1);
      if (a % 97 == 0) idle(a % 4 + 1);
    end
    idle(8);

    chk(received == issued && q_e7.size() == 0, "R10 result count", received, issued);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule